// File: doc/BRIEF.md
# I2C Slave Control Register File

This block lets a host on a two-wire I2C bus read and write a bank of byte-wide control registers. The slave answers on one of two 7-bit addresses, and a strap input picks which one. The block watches SCL and SDA through synchronizers on the system clock. It finds START and STOP conditions, decodes the address byte and acknowledges a match. It pulls SDA low through an open-drain enable and never drives the line high.

After the address byte of a write, the next byte loads an internal register pointer. Each following byte is stored at the pointer, and the pointer then moves on. A read returns bytes from the pointer onward for as long as the master acknowledges. The pointer keeps its value from one transfer to the next, so a read with no pointer byte continues from where the last access stopped. A read that first sets the pointer and then sends a repeated START gives random access. The whole register image is presented in parallel to the rest of the chip. Each register has a fixed reset value.

Top module: `i2c_regfile_slave`

## Requirements
- R1: The slave answers the 7-bit address 0x20 when `addr_sel`=0 and 0x21 when `addr_sel`=1, so the first byte is 0x40/0x41 or 0x42/0x43. The address byte is received MSB first, and its bit 0 is the direction (1 = read). On a match the slave pulls SDA low during the 9th SCL pulse. On a mismatch `sda_oe` stays 0 until the next START.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A START at any point, including in the middle of a byte, drops the partial byte and restarts address reception. A STOP in the middle of a byte drops it, so no register changes.
- R3: In a write, the byte after the address loads the pointer, and every later byte is stored in the register at the pointer. The slave acknowledges both kinds of byte.
- R4: The pointer advances by one after each data byte written or read. It wraps to 0x00 after 0x59. A pointer above 0x59 stores nothing, reads as 0x00 and becomes 0x00 after that byte.
- R5: A read that sends only the address byte with the read bit set returns data starting at the pointer left by the previous transfer. The pointer is 0x00 after reset.
- R6: A random read (write the address, send the pointer byte, repeated START, send the address with the read bit set) returns data starting at the new pointer.
- R7: A read goes on byte after byte while the master acknowledges. After a master NACK the slave releases SDA and leaves it released until the next START.
- R8: Read data goes out MSB first. SDA is changed only after a falling SCL edge, so it is stable while SCL is high.
- R9: After reset, register 0x00 = 0x83, 0x03 = 0xC2, 0x07 = 0x7E and 0x0A = 0xFF. Every other register is 0x00. Register i appears on `reg_flat[8i+7:8i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| addr_sel | input | 1 | Strap that picks the device address |
| scl_in | input | 1 | Bus clock as received |
| sda_in | input | 1 | Bus data as received (wired level) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_flat | output | 720 | Parallel image of all 90 registers |

## Verification
The hardest cases to reach are a START or STOP that lands in the middle of a byte, and the quiet state after a master NACK. A normal master produces neither. The bench drives the bus one bit at a time. It cuts an address byte short with a repeated START and cuts a data byte short with a STOP. After a NACK it clocks a further byte of zeros and counts the system-clock cycles in which `sda_oe` is high. Pointer wrap and out-of-range pointers are reached with directed writes and reads at 0x57 to 0x59 and 0xF0. A seeded random mix of writes, random reads and current-address reads is then checked against a model of the register image.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

    localparam int NUM_REGS = 90;
    localparam int PTR_W    = 8;
    localparam logic [5:0] DEV_ADDR_HI = 6'b010000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_WR,
        ST_RD
    } eng_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic [7:0] reset_value(input int idx);
        case (idx)
            0:       return 8'h83;
            3:       return 8'hC2;
            7:       return 8'h7E;
            10:      return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p,
                                                  input logic [PTR_W-1:0] last);
        return (p >= last) ? '0 : p + 1'b1;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_rf_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_raw,
    input  logic    sda_raw,
    output bus_ev_t ev
);
    // bit 1 = SCL, bit 0 = SDA
    logic [1:0] pipe [STAGES];
    logic [1:0] prev;
    logic [1:0] cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= 2'b11;
            prev <= 2'b11;
        end else begin
            pipe[0] <= {scl_raw, sda_raw};
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            prev <= pipe[STAGES-1];
        end
    end

    assign cur = pipe[STAGES-1];

    always_comb begin
        ev.scl      = cur[1];
        ev.sda      = cur[0];
        ev.scl_rise = cur[1] & ~prev[1];
        ev.scl_fall = ~cur[1] & prev[1];
        ev.start    = cur[1] & prev[1] & prev[0] & ~cur[0];
        ev.stop     = cur[1] & prev[1] & ~prev[0] & cur[0];
    end

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
    import i2c_rf_pkg::*;
#(
    parameter int NREGS = NUM_REGS,
    parameter int PW    = PTR_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [PW-1:0]      wr_addr,
    input  logic [7:0]         wr_data,
    input  logic [PW-1:0]      rd_addr,
    output logic [7:0]         rd_data,
    output logic [NREGS*8-1:0] flat
);
    localparam int            IDX_W = $clog2(NREGS);
    localparam logic [PW-1:0] LAST  = PW'(NREGS - 1);

    logic [7:0]       bank [NREGS];
    logic [IDX_W-1:0] ridx;
    logic [IDX_W-1:0] widx;

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= reset_value(g);
            else if (wr_en && wr_addr == PW'(g))
                q <= wr_data;
        end
        assign bank[g]          = q;
        assign flat[g*8 +: 8]   = q;
    end

    assign ridx    = rd_addr[IDX_W-1:0];
    assign widx    = wr_addr[IDX_W-1:0];
    assign rd_data = (rd_addr <= LAST) ? bank[ridx] : 8'h00;

    // R3: an in-range write lands in the addressed register
    a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr <= LAST) |=> (bank[$past(widx)] == $past(wr_data)));

    // R4: a write through an out-of-range pointer changes nothing
    a_r4_oob_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr > LAST) |=> $stable(flat));

endmodule

// File: rtl/i2c_proto_fsm.sv
module i2c_proto_fsm
    import i2c_rf_pkg::*;
#(
    parameter int NREGS = NUM_REGS,
    parameter int PW    = PTR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_ev_t       ev,
    input  logic          addr_sel,
    input  logic [7:0]    rd_data,
    output logic [PW-1:0] ptr,
    output logic          wr_en,
    output logic [PW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          sda_oe
);
    localparam logic [PW-1:0] LAST = PW'(NREGS - 1);

    eng_state_e state;
    logic [3:0] bitcnt;
    logic [7:0] shreg;
    logic [7:0] txbyte;
    logic       rd_dir;
    logic       mack;

    always_ff @(posedge clk) begin
        wr_en <= 1'b0;
        if (rst) begin
            state   <= ST_IDLE;
            bitcnt  <= '0;
            shreg   <= '0;
            txbyte  <= '0;
            rd_dir  <= 1'b0;
            mack    <= 1'b0;
            ptr     <= '0;
            wr_addr <= '0;
            wr_data <= '0;
            sda_oe  <= 1'b0;
        end else if (ev.start) begin
            state  <= ST_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else if (ev.stop) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else if (state != ST_IDLE) begin
            if (ev.scl_rise) begin
                if (bitcnt == 4'd8) begin
                    bitcnt <= 4'd9;
                    if (state == ST_RD) mack <= ~ev.sda;
                end else if (bitcnt < 4'd8) begin
                    bitcnt <= bitcnt + 4'd1;
                    shreg  <= {shreg[6:0], ev.sda};
                end
            end else if (ev.scl_fall) begin
                if (state == ST_RD) begin
                    if (bitcnt >= 4'd1 && bitcnt <= 4'd7) begin
                        sda_oe <= ~txbyte[3'd7 - bitcnt[2:0]];
                    end else if (bitcnt == 4'd8) begin
                        sda_oe <= 1'b0;
                    end else if (bitcnt == 4'd9) begin
                        bitcnt <= '0;
                        if (mack) begin
                            txbyte <= rd_data;
                            ptr    <= ptr_next(ptr, LAST);
                            sda_oe <= ~rd_data[7];
                        end else begin
                            state  <= ST_IDLE;
                            sda_oe <= 1'b0;
                        end
                    end
                end else if (bitcnt == 4'd8) begin
                    case (state)
                        ST_ADDR: begin
                            if (shreg[7:1] == {DEV_ADDR_HI, addr_sel}) begin
                                sda_oe <= 1'b1;
                                rd_dir <= shreg[0];
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                        ST_PTR: begin
                            ptr    <= shreg;
                            sda_oe <= 1'b1;
                        end
                        ST_WR: begin
                            wr_en   <= 1'b1;
                            wr_addr <= ptr;
                            wr_data <= shreg;
                            ptr     <= ptr_next(ptr, LAST);
                            sda_oe  <= 1'b1;
                        end
                        default: ;
                    endcase
                end else if (bitcnt == 4'd9) begin
                    bitcnt <= '0;
                    sda_oe <= 1'b0;
                    case (state)
                        ST_ADDR: begin
                            if (rd_dir) begin
                                state  <= ST_RD;
                                txbyte <= rd_data;
                                ptr    <= ptr_next(ptr, LAST);
                                sda_oe <= ~rd_data[7];
                            end else begin
                                state <= ST_PTR;
                            end
                        end
                        ST_PTR:  state <= ST_WR;
                        default: ;
                    endcase
                end
            end
        end
    end

    // R1: an idle engine (mismatch, NACK, STOP) never pulls the line
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe);

    // R8: the drive changes only after a falling SCL or a bus condition
    a_r8_sda_scl_low: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> ($past(ev.scl_fall) || $past(ev.start) || $past(ev.stop)));

    // R2: a START always restarts address reception with the line released
    a_r2_start_restarts: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (state == ST_ADDR && bitcnt == 4'd0 && !sda_oe));

    // R3: outside a read the slave drives only in the acknowledge slot
    a_r3_ack_slot: assert property (@(posedge clk) disable iff (rst)
        (sda_oe && state != ST_RD) |-> (bitcnt >= 4'd8));

    // R7: a master NACK ends the read and releases SDA
    a_r7_nack_ends: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD && ev.scl_fall && bitcnt == 4'd9 && !mack) |=> (state == ST_IDLE && !sda_oe));

endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave
    import i2c_rf_pkg::*;
#(
    parameter int NREGS       = NUM_REGS,
    parameter int PW          = PTR_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               addr_sel,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_oe,
    output logic [NREGS*8-1:0] reg_flat
);
    bus_ev_t       ev;
    logic [PW-1:0] ptr;
    logic          wr_en;
    logic [PW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic [7:0]    rd_data;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .scl_raw (scl_in),
        .sda_raw (sda_in),
        .ev      (ev)
    );

    i2c_proto_fsm #(.NREGS(NREGS), .PW(PW)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .addr_sel (addr_sel),
        .rd_data  (rd_data),
        .ptr      (ptr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .sda_oe   (sda_oe)
    );

    i2c_reg_bank #(.NREGS(NREGS), .PW(PW)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (ptr),
        .rd_data (rd_data),
        .flat    (reg_flat)
    );

endmodule

// File: tb/tb_i2c_regfile_slave.sv
`timescale 1ns/1ps
module tb_i2c_regfile_slave;

    localparam int NREGS = 90;
    localparam int Q     = 50;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic addr_sel = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [NREGS*8-1:0] reg_flat;

    assign sda_line = sda_m & ~sda_oe;

    i2c_regfile_slave dut (
        .clk      (clk),
        .rst      (rst),
        .addr_sel (addr_sel),
        .scl_in   (scl_m),
        .sda_in   (sda_line),
        .sda_oe   (sda_oe),
        .reg_flat (reg_flat)
    );

    always #2.5 clk = ~clk;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    int   drv_total = 0;
    logic [7:0] mdl [NREGS];
    logic [7:0] mptr;
    logic [7:0] wbuf [8];

    always @(posedge clk) if (sda_oe) drv_total <= drv_total + 1;

    function automatic logic [7:0] exp_reset(input int i);
        if (i == 10) return 8'hFF;
        if (i == 7)  return 8'h7E;
        if (i == 3)  return 8'hC2;
        if (i == 0)  return 8'h83;
        return 8'h00;
    endfunction

    function automatic logic [7:0] nxt(input logic [7:0] p);
        return (p >= 8'h59) ? 8'h00 : p + 8'h01;
    endfunction

    function automatic logic [7:0] mread(input logic [7:0] p);
        return (p <= 8'h59) ? mdl[p] : 8'h00;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_flat(input string req);
        int bad = 0;
        for (int i = 0; i < NREGS; i++)
            if (reg_flat[i*8 +: 8] !== mdl[i]) bad++;
        chk(req, "register image mismatching bytes", bad, 0);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; #Q;
        scl_m = 1'b1; #Q;
        sda_m = 1'b0; #Q;
        scl_m = 1'b0; #Q;
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; #Q;
        scl_m = 1'b1; #Q;
        sda_m = 1'b1; #Q;
    endtask

    task automatic i2c_bit(input logic b, output logic s);
        sda_m = b; #Q;
        scl_m = 1'b1; #Q;
        s = sda_line; #Q;
        scl_m = 1'b0; #Q;
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) i2c_bit(d[i], s);
        i2c_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        logic s;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            i2c_bit(1'b1, s);
            d = {d[6:0], s};
        end
        i2c_bit(~give_ack, s);
    endtask

    task automatic do_write(input logic [7:0] p, input int n, input string req);
        logic a;
        i2c_start();
        send_byte({6'b010000, addr_sel, 1'b0}, a);
        chk(req, "device ack (write)", a, 1);
        send_byte(p, a);
        chk(req, "pointer ack", a, 1);
        mptr = p;
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], a);
            chk(req, "data ack", a, 1);
            if (mptr <= 8'h59) mdl[mptr] = wbuf[k];
            mptr = nxt(mptr);
        end
        i2c_stop();
    endtask

    task automatic read_body(input int n, input string req);
        logic [7:0] d;
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, d);
            chk(req, "read data", d, mread(mptr));
            mptr = nxt(mptr);
        end
    endtask

    task automatic do_read_cur(input int n, input string req);
        logic a;
        i2c_start();
        send_byte({6'b010000, addr_sel, 1'b1}, a);
        chk(req, "device ack (read)", a, 1);
        read_body(n, req);
        i2c_stop();
    endtask

    task automatic do_read_rand(input logic [7:0] p, input int n, input string req);
        logic a;
        i2c_start();
        send_byte({6'b010000, addr_sel, 1'b0}, a);
        chk(req, "device ack (write phase)", a, 1);
        send_byte(p, a);
        chk(req, "pointer ack", a, 1);
        mptr = p;
        i2c_start();
        send_byte({6'b010000, addr_sel, 1'b1}, a);
        chk(req, "device ack (read phase)", a, 1);
        read_body(n, req);
        i2c_stop();
    endtask

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: requirement none, actual hung, expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic a;
        logic s;
        logic [7:0] d;
        int d0;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NREGS; i++) mdl[i] = exp_reset(i);
        mptr = 8'h00;
        repeat (6) @(posedge clk);
        #1 rst = 1'b0;
        repeat (4) @(posedge clk);
        #1;

        // R9: reset image, and sda released
        check_flat("R9");
        chk("R9", "sda_oe after reset", sda_oe, 0);

        // R5 / R9: current-address read from pointer 0 after reset
        do_read_cur(2, "R5");

        // R1: wrong address (strap 0, byte 0x42) -> no ack and no drive
        d0 = drv_total;
        i2c_start();
        send_byte(8'h42, a);
        chk("R1", "ack on foreign address", a, 0);
        send_byte(8'h05, a);
        i2c_stop();
        chk("R1", "drive cycles on mismatch", drv_total - d0, 0);

        // R1 / R3: strap 1 answers 0x21
        addr_sel = 1'b1;
        #Q;
        wbuf[0] = 8'h5A;
        do_write(8'h05, 1, "R1");
        chk("R3", "register 0x05 after write", reg_flat[5*8 +: 8], 8'h5A);
        addr_sel = 1'b0;
        #Q;

        // R4: multi-byte write across the wrap point
        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
        do_write(8'h58, 3, "R4");
        chk("R4", "register 0x58", reg_flat[8'h58*8 +: 8], 8'hA1);
        chk("R4", "register 0x59", reg_flat[8'h59*8 +: 8], 8'hB2);
        chk("R4", "register 0x00 after wrap", reg_flat[7:0], 8'hC3);

        // R6 / R4: random read that wraps
        do_read_rand(8'h57, 4, "R6");
        // R5: continues at pointer 0x01
        do_read_cur(1, "R5");

        // R7: sequential read, NACK, then slave stays off the bus
        i2c_start();
        send_byte(8'h41, a);
        chk("R7", "device ack", a, 1);
        read_body(2, "R7");
        d0 = drv_total;
        send_byte(8'h00, a);
        chk("R7", "ack after NACK", a, 0);
        chk("R7", "drive cycles after NACK", drv_total - d0, 0);
        i2c_stop();

        // R4: out-of-range pointer write is ignored, pointer becomes 0
        wbuf[0] = 8'h11;
        do_write(8'hF0, 1, "R4");
        check_flat("R4");
        do_read_cur(1, "R4");
        do_read_rand(8'hF0, 1, "R4");

        // R2: START in the middle of an address byte aborts it
        i2c_start();
        i2c_bit(1'b0, s); i2c_bit(1'b1, s); i2c_bit(1'b0, s); i2c_bit(1'b0, s);
        wbuf[0] = 8'h77;
        do_write(8'h10, 1, "R2");
        chk("R2", "register 0x10 after aborted byte", reg_flat[8'h10*8 +: 8], 8'h77);

        // R2: STOP in the middle of a data byte drops it
        i2c_start();
        send_byte(8'h40, a);
        chk("R2", "device ack", a, 1);
        send_byte(8'h11, a);
        chk("R2", "pointer ack", a, 1);
        mptr = 8'h11;
        i2c_bit(1'b1, s); i2c_bit(1'b1, s); i2c_bit(1'b1, s);
        i2c_stop();
        check_flat("R2");
        do_read_cur(1, "R2");

        // R3 / R5 / R6: seeded random mix against the model
        for (int it = 0; it < 25; it++) begin
            int op;
            int n;
            logic [7:0] p;
            op = int'($urandom_range(0, 2));
            n  = int'($urandom_range(1, 4));
            p  = 8'($urandom_range(0, 8'h59));
            if (op == 0) begin
                for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom_range(0, 255));
                do_write(p, n, "R3");
            end else if (op == 1) begin
                do_read_rand(p, n, "R6");
            end else begin
                do_read_cur(n, "R5");
            end
        end
        check_flat("R3");

        // R8: read data MSB first from a known pattern
        wbuf[0] = 8'h96;
        do_write(8'h20, 1, "R8");
        do_read_rand(8'h20, 1, "R8");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule